// File: doc/BRIEF.md
# Slave Re-arbitration Point Detector

This block sits beside the arbiter of one slave port in an AHB-style crossbar. It watches the transfer that the current owner is running on that port. It raises a strobe in each cycle that follows a cycle in which a change of ownership would not break a transfer, so the arbiter can safely pick a new master.

A cycle qualifies as such a point in four cases:

- the port has no owner, or its owner issues IDLE;
- a single (non-burst) transfer completes;
- the last beat of a fixed-length burst completes, or a predicted end inside an undefined-length incrementing burst is reached (never, every 4 beats or every 8 beats, set by a select input);
- the owner has held the port for a programmable number of cycles without reaching any other point.

Grant selection and the data path are handled elsewhere.

Top module: `rearb_point_detect`

## Requirements
- R1: While `rst` is high at a clock edge, `rearb_o` is low in the following cycle. Both internal counters clear.
- R2: When `owner_valid_i` is low, or `htrans_i` is IDLE (2'b00), in a cycle, `rearb_o` is high in the next cycle.
- R3: A completed single transfer makes `rearb_o` high in the next cycle. This is `htrans_i` NONSEQ (2'b10), `hburst_i` SINGLE (3'b000) and `hready_i` high.
- R4: Fixed bursts fire only on the completed beat whose count equals the burst length. The `hburst_i` codes are WRAP4 3'b010 and INCR4 3'b011 (4 beats), WRAP8 3'b100 and INCR8 3'b101 (8 beats), WRAP16 3'b110 and INCR16 3'b111 (16 beats). A beat completes on NONSEQ or SEQ (2'b11) with `hready_i` high, and a completed NONSEQ is beat 1.
- R5: These cycles count no beat and, with the slot limit at 0, produce no strobe: a NONSEQ or SEQ cycle with `hready_i` low, and a BUSY (2'b01) cycle.
- R6: For an undefined-length burst (`hburst_i` 3'b001) with `incr_end_sel_i` 2'b00 or 2'b11, no beat produces a strobe.
- R7: For `hburst_i` 3'b001, `incr_end_sel_i` 2'b01 fires on every completed beat whose count is a multiple of 4. The value 2'b10 fires on every multiple of 8.
- R8: With `slot_limit_i` = L > 0, the slot count holds the number of owned cycles since the last qualifying cycle. A cycle in which that count is at least L qualifies.
- R9: With `slot_limit_i` = 0 the slot count never causes a strobe.
- R10: The slot count restarts from 0 after every qualifying cycle, whatever its cause. Stalled cycles count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| owner_valid_i | input | 1 | The port currently has an owning master |
| htrans_i | input | 2 | Transfer type of the owner |
| hburst_i | input | 3 | Burst type of the owner |
| hready_i | input | 1 | Slave ready; a beat completes when high |
| incr_end_sel_i | input | 2 | Predicted-end spacing for undefined-length bursts |
| slot_limit_i | input | SLOT_W | Slot cycle limit, 0 disables |
| rearb_o | output | 1 | Registered re-arbitration strobe |

## Verification
The strobe is registered, so any wrong decision shows at `rearb_o` exactly one cycle after the cycle that caused it.

A beat counter that drifts shows up within one burst, at most 16 beats. The strobe then lands on the wrong beat of a fixed burst, or off the 4 or 8 boundary of an undefined-length burst.

A slot counter that fails to clear or to count shows within L+1 owned cycles, as a strobe that comes early, comes late or is missing. The bench therefore checks every beat of each burst shape and runs two back-to-back slot windows, one of them containing stalls.

// File: rtl/rearb_point_pkg.sv
package rearb_point_pkg;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  typedef enum logic [2:0] {
    BU_SINGLE = 3'b000,
    BU_INCR   = 3'b001,
    BU_WRAP4  = 3'b010,
    BU_INCR4  = 3'b011,
    BU_WRAP8  = 3'b100,
    BU_INCR8  = 3'b101,
    BU_WRAP16 = 3'b110,
    BU_INCR16 = 3'b111
  } burst_e;

  typedef enum logic [1:0] {
    PE_NEVER  = 2'b00,
    PE_FOUR   = 2'b01,
    PE_EIGHT  = 2'b10,
    PE_NEVER2 = 2'b11
  } pend_e;

  localparam int unsigned MAX_FIXED_LEN = 16;

  // Beat count of a fixed-length burst; 0 for single and undefined length.
  function automatic int unsigned burst_len(logic [2:0] code);
    case (code)
      BU_WRAP4,  BU_INCR4:  return 4;
      BU_WRAP8,  BU_INCR8:  return 8;
      BU_WRAP16, BU_INCR16: return 16;
      default:              return 0;
    endcase
  endfunction

endpackage

// File: rtl/rap_beat_track.sv
module rap_beat_track
  import rearb_point_pkg::*;
#(
  parameter int BEAT_W = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] htrans_i,
  input  logic [2:0] hburst_i,
  input  logic       hready_i,
  input  logic [1:0] incr_end_sel_i,
  output logic       burst_end_o
);

  localparam int N_SPACING = 2;  // predicted-end spacings 4 and 8

  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_now;
  logic [BEAT_W-1:0] len_v;
  logic              beat_done;
  logic              fixed_end;
  logic              incr_end;
  logic [N_SPACING-1:0] on_bound;

  assign beat_done = hready_i && (htrans_i == TR_NSEQ || htrans_i == TR_SEQ);
  assign beat_now  = (htrans_i == TR_NSEQ) ? BEAT_W'(1) : beat_q + BEAT_W'(1);
  assign len_v     = BEAT_W'(burst_len(hburst_i));

  always_ff @(posedge clk) begin
    if (rst)            beat_q <= '0;
    else if (beat_done) beat_q <= beat_now;
  end

  // Boundary detectors for spacing 2^(g+2) beats.
  for (genvar g = 0; g < N_SPACING; g++) begin : g_bound
    localparam int LOGN = g + 2;
    assign on_bound[g] = (beat_now[LOGN-1:0] == '0);
  end

  assign fixed_end = beat_done && (len_v != '0) && (beat_now == len_v);
  assign incr_end  = beat_done && (hburst_i == BU_INCR) &&
                     ((incr_end_sel_i == PE_FOUR  && on_bound[0]) ||
                      (incr_end_sel_i == PE_EIGHT && on_bound[1]));

  assign burst_end_o = fixed_end || incr_end;

  // R6: infinite setting never predicts an end
  a_r6_never_breaks: assert property (@(posedge clk) disable iff (rst)
    (hburst_i == BU_INCR &&
     (incr_end_sel_i == PE_NEVER || incr_end_sel_i == PE_NEVER2)) |-> !burst_end_o);

  // R5: an uncompleted beat is never an end point
  a_r5_no_end_on_stall: assert property (@(posedge clk) disable iff (rst)
    !hready_i |-> !burst_end_o);

endmodule

// File: rtl/rap_slot_timer.sv
module rap_slot_timer #(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              owner_i,
  input  logic              clear_i,
  input  logic [SLOT_W-1:0] limit_i,
  output logic              hit_o,
  output logic [SLOT_W-1:0] count_o
);

  localparam logic [SLOT_W-1:0] CNT_MAX = '1;

  logic [SLOT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i)                    count_q <= '0;
    else if (owner_i && count_q != CNT_MAX) count_q <= count_q + 1'b1;
  end

  assign hit_o   = owner_i && (limit_i != '0) && (count_q >= limit_i);
  assign count_o = count_q;

  // R9: a zero limit never produces a hit
  a_r9_limit_off: assert property (@(posedge clk) disable iff (rst)
    (limit_i == '0) |-> !hit_o);

endmodule

// File: rtl/rearb_point_detect.sv
module rearb_point_detect
  import rearb_point_pkg::*;
#(
  parameter int SLOT_W   = 8,
  parameter int MAX_BEAT = MAX_FIXED_LEN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              owner_valid_i,
  input  logic [1:0]        htrans_i,
  input  logic [2:0]        hburst_i,
  input  logic              hready_i,
  input  logic [1:0]        incr_end_sel_i,
  input  logic [SLOT_W-1:0] slot_limit_i,
  output logic              rearb_o
);

  localparam int BEAT_W = $clog2(MAX_BEAT + 1);

  logic              idle_pt;
  logic              single_pt;
  logic              burst_end;
  logic              slot_hit;
  logic              any_pt;
  logic              rearb_q;
  logic [SLOT_W-1:0] slot_cnt;

  rap_beat_track #(.BEAT_W(BEAT_W)) u_beat (
    .clk            (clk),
    .rst            (rst),
    .htrans_i       (htrans_i),
    .hburst_i       (hburst_i),
    .hready_i       (hready_i),
    .incr_end_sel_i (incr_end_sel_i),
    .burst_end_o    (burst_end)
  );

  rap_slot_timer #(.SLOT_W(SLOT_W)) u_slot (
    .clk     (clk),
    .rst     (rst),
    .owner_i (owner_valid_i),
    .clear_i (any_pt),
    .limit_i (slot_limit_i),
    .hit_o   (slot_hit),
    .count_o (slot_cnt)
  );

  assign idle_pt   = !owner_valid_i || (htrans_i == TR_IDLE);
  assign single_pt = owner_valid_i && hready_i &&
                     (htrans_i == TR_NSEQ) && (hburst_i == BU_SINGLE);
  assign any_pt    = idle_pt || single_pt || (owner_valid_i && burst_end) || slot_hit;

  always_ff @(posedge clk) begin
    if (rst) rearb_q <= 1'b0;
    else     rearb_q <= any_pt;
  end

  assign rearb_o = rearb_q;

  // R1: reset forces the strobe low
  a_r1_reset_low: assert property (@(posedge clk) rst |=> !rearb_o);

  // R2: idle port or idle owner fires next cycle
  a_r2_idle_fires: assert property (@(posedge clk) disable iff (rst)
    (!owner_valid_i || htrans_i == TR_IDLE) |=> rearb_o);

  // R3: completed single transfer fires next cycle
  a_r3_single_fires: assert property (@(posedge clk) disable iff (rst)
    (owner_valid_i && hready_i && htrans_i == TR_NSEQ && hburst_i == BU_SINGLE) |=> rearb_o);

  // R5: stalled owned transfer with limit off stays quiet
  a_r5_stall_quiet: assert property (@(posedge clk) disable iff (rst)
    (owner_valid_i && htrans_i != TR_IDLE && !hready_i && slot_limit_i == '0) |=> !rearb_o);

  // R10: slot count is zero whenever the strobe is up
  a_r10_clear_on_fire: assert property (@(posedge clk) disable iff (rst)
    rearb_o |-> (slot_cnt == '0));

  // R8: reaching the limit fires next cycle
  a_r8_slot_fires: assert property (@(posedge clk) disable iff (rst)
    (owner_valid_i && slot_limit_i != '0 && slot_cnt >= slot_limit_i) |=> rearb_o);

endmodule

// File: tb/rearb_point_detect_tb_top.sv
module rearb_point_detect_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       owner_valid_i;
  logic [1:0] htrans_i;
  logic [2:0] hburst_i;
  logic       hready_i;
  logic [1:0] incr_end_sel_i;
  logic [7:0] slot_limit_i;
  logic       rearb_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #4 clk = ~clk;  // 125 MHz

  rearb_point_detect #(.SLOT_W(8)) dut_i (
    .clk            (clk),
    .rst            (rst),
    .owner_valid_i  (owner_valid_i),
    .htrans_i       (htrans_i),
    .hburst_i       (hburst_i),
    .hready_i       (hready_i),
    .incr_end_sel_i (incr_end_sel_i),
    .slot_limit_i   (slot_limit_i),
    .rearb_o        (rearb_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog expired: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  typedef struct packed {
    logic       own;
    logic [1:0] tr;
    logic [2:0] hb;
    logic       rdy;
    logic [1:0] sel;
    logic [7:0] lim;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 44;
  // Tags: R2 idle, R3 single, R4 fixed end, R5 stall/busy, R7 spacing, R8 slot, R10 restart
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 3'd0, 1'b1, 2'd0, 8'd0, 1'b1, 4'd2},  // R2 no owner
    '{1'b1, 2'd0, 3'd0, 1'b1, 2'd0, 8'd0, 1'b1, 4'd2},  // R2 owner idle
    '{1'b1, 2'd2, 3'd0, 1'b1, 2'd0, 8'd0, 1'b1, 4'd3},  // R3 single
    '{1'b1, 2'd2, 3'd0, 1'b0, 2'd0, 8'd0, 1'b0, 4'd5},  // R5 single stalled
    '{1'b1, 2'd2, 3'd0, 1'b1, 2'd0, 8'd0, 1'b1, 4'd3},
    '{1'b1, 2'd2, 3'd3, 1'b1, 2'd0, 8'd0, 1'b0, 4'd4},  // INCR4 beat1
    '{1'b1, 2'd3, 3'd3, 1'b1, 2'd0, 8'd0, 1'b0, 4'd4},  // beat2
    '{1'b1, 2'd3, 3'd3, 1'b0, 2'd0, 8'd0, 1'b0, 4'd5},  // stall
    '{1'b1, 2'd1, 3'd3, 1'b1, 2'd0, 8'd0, 1'b0, 4'd5},  // BUSY
    '{1'b1, 2'd3, 3'd3, 1'b1, 2'd0, 8'd0, 1'b0, 4'd4},  // beat3
    '{1'b1, 2'd3, 3'd3, 1'b1, 2'd0, 8'd0, 1'b1, 4'd4},  // beat4 end
    '{1'b1, 2'd2, 3'd4, 1'b1, 2'd0, 8'd0, 1'b0, 4'd4},  // WRAP8 beat1
    '{1'b1, 2'd3, 3'd4, 1'b1, 2'd0, 8'd0, 1'b0, 4'd4},
    '{1'b1, 2'd3, 3'd4, 1'b1, 2'd0, 8'd0, 1'b0, 4'd4},
    '{1'b1, 2'd3, 3'd4, 1'b1, 2'd0, 8'd0, 1'b0, 4'd4},
    '{1'b1, 2'd3, 3'd4, 1'b1, 2'd0, 8'd0, 1'b0, 4'd4},
    '{1'b1, 2'd3, 3'd4, 1'b1, 2'd0, 8'd0, 1'b0, 4'd4},
    '{1'b1, 2'd3, 3'd4, 1'b1, 2'd0, 8'd0, 1'b0, 4'd4},
    '{1'b1, 2'd3, 3'd4, 1'b1, 2'd0, 8'd0, 1'b1, 4'd4},  // beat8 end
    '{1'b1, 2'd2, 3'd1, 1'b1, 2'd1, 8'd0, 1'b0, 4'd7},  // INCR every 4
    '{1'b1, 2'd3, 3'd1, 1'b1, 2'd1, 8'd0, 1'b0, 4'd7},
    '{1'b1, 2'd3, 3'd1, 1'b1, 2'd1, 8'd0, 1'b0, 4'd7},
    '{1'b1, 2'd3, 3'd1, 1'b1, 2'd1, 8'd0, 1'b1, 4'd7},  // beat4
    '{1'b1, 2'd3, 3'd1, 1'b1, 2'd1, 8'd0, 1'b0, 4'd7},
    '{1'b1, 2'd3, 3'd1, 1'b1, 2'd1, 8'd0, 1'b0, 4'd7},
    '{1'b1, 2'd3, 3'd1, 1'b1, 2'd1, 8'd0, 1'b0, 4'd7},
    '{1'b1, 2'd3, 3'd1, 1'b1, 2'd1, 8'd0, 1'b1, 4'd7},  // beat8
    '{1'b1, 2'd2, 3'd1, 1'b1, 2'd2, 8'd0, 1'b0, 4'd7},  // INCR every 8
    '{1'b1, 2'd3, 3'd1, 1'b1, 2'd2, 8'd0, 1'b0, 4'd7},
    '{1'b1, 2'd3, 3'd1, 1'b1, 2'd2, 8'd0, 1'b0, 4'd7},
    '{1'b1, 2'd3, 3'd1, 1'b1, 2'd2, 8'd0, 1'b0, 4'd7},  // beat4 quiet
    '{1'b1, 2'd3, 3'd1, 1'b1, 2'd2, 8'd0, 1'b0, 4'd7},
    '{1'b1, 2'd3, 3'd1, 1'b1, 2'd2, 8'd0, 1'b0, 4'd7},
    '{1'b1, 2'd3, 3'd1, 1'b1, 2'd2, 8'd0, 1'b0, 4'd7},
    '{1'b1, 2'd3, 3'd1, 1'b1, 2'd2, 8'd0, 1'b1, 4'd7},  // beat8
    '{1'b1, 2'd0, 3'd0, 1'b1, 2'd0, 8'd0, 1'b1, 4'd2},  // idle, clears slot count
    '{1'b1, 2'd2, 3'd1, 1'b1, 2'd0, 8'd3, 1'b0, 4'd8},  // count 0
    '{1'b1, 2'd3, 3'd1, 1'b1, 2'd0, 8'd3, 1'b0, 4'd8},  // 1
    '{1'b1, 2'd3, 3'd1, 1'b1, 2'd0, 8'd3, 1'b0, 4'd8},  // 2
    '{1'b1, 2'd3, 3'd1, 1'b1, 2'd0, 8'd3, 1'b1, 4'd8},  // 3 -> hit
    '{1'b1, 2'd3, 3'd1, 1'b0, 2'd0, 8'd3, 1'b0, 4'd10}, // restarted, stall counts
    '{1'b1, 2'd3, 3'd1, 1'b1, 2'd0, 8'd3, 1'b0, 4'd10},
    '{1'b1, 2'd3, 3'd1, 1'b1, 2'd0, 8'd3, 1'b0, 4'd10},
    '{1'b1, 2'd3, 3'd1, 1'b0, 2'd0, 8'd3, 1'b1, 4'd10}  // second window hit
  };

  task automatic chk(input logic got, input logic exp, input string req);
    n_tests = n_tests + 1;
    if (got !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: rearb_o got %b expected %b (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  task automatic drive(input logic own, input logic [1:0] tr, input logic [2:0] hb,
                       input logic rdy, input logic [1:0] sel, input logic [7:0] lim);
    owner_valid_i  = own;
    htrans_i       = tr;
    hburst_i       = hb;
    hready_i       = rdy;
    incr_end_sel_i = sel;
    slot_limit_i   = lim;
  endtask

  // Expected strobe for completed beat idx of a burst, from R4, R6, R7.
  function automatic logic exp_beat(input logic [2:0] hb, input int idx, input logic [1:0] sel);
    int len;
    case (hb)
      3'd2, 3'd3: len = 4;
      3'd4, 3'd5: len = 8;
      3'd6, 3'd7: len = 16;
      default:    len = 0;
    endcase
    if (hb == 3'd0) return 1'b1;
    if (hb == 3'd1) begin
      if (sel == 2'd1) return (idx % 4) == 0;
      if (sel == 2'd2) return (idx % 8) == 0;
      return 1'b0;
    end
    return idx == len;
  endfunction

  task automatic run_burst(input logic [2:0] hb, input int nbeats, input logic [1:0] sel,
                           input string req);
    for (int b = 1; b <= nbeats; b++) begin
      drive(1'b1, (b == 1) ? 2'd2 : 2'd3, hb, 1'b1, sel, 8'd0);
      @(negedge clk);
      chk(rearb_o, exp_beat(hb, b, sel), req);
    end
  endtask

  initial begin
    drive(1'b0, 2'd0, 3'd0, 1'b1, 2'd0, 8'd0);
    rst = 1'b1;
    // R1: strobe low during reset even with idle inputs
    @(negedge clk);
    chk(rearb_o, 1'b0, "R1");
    @(negedge clk);
    chk(rearb_o, 1'b0, "R1");
    // R1: counters cleared, first INCR4 beat after reset is beat1
    drive(1'b1, 2'd2, 3'd3, 1'b1, 2'd0, 8'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(rearb_o, 1'b0, "R1");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].own, VEC[i].tr, VEC[i].hb, VEC[i].rdy, VEC[i].sel, VEC[i].lim);
      @(negedge clk);
      chk(rearb_o, VEC[i].exp, $sformatf("R%0d row %0d", VEC[i].req, i));
    end

    run_burst(3'd7, 16, 2'd0, "R4 INCR16");
    run_burst(3'd2, 4,  2'd0, "R4 WRAP4");
    run_burst(3'd6, 16, 2'd0, "R4 WRAP16");
    run_burst(3'd5, 8,  2'd0, "R4 INCR8");
    run_burst(3'd1, 12, 2'd1, "R7 INCR four");
    run_burst(3'd1, 20, 2'd3, "R6 INCR sel3");
    // R9: long infinite INCR with limit 0 never fires
    run_burst(3'd1, 40, 2'd0, "R9 R6 long INCR");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule